// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the two wires of an I2C bus from inside a synchronous system. It resamples the raw clock and data lines through a two-flop synchronizer. From the resampled levels it recognises the three framing events of the bus: a Start, a Repeated Start and a Stop. Each event is reported as a one-cycle pulse in the system clock domain.

The block also keeps a bus-busy flag and drives a sticky interrupt request line. The line rises on an enabled Start or Stop and falls when software pulses a clear input. Two enable inputs select which event kinds may raise the interrupt. A mode input marks slave modes that interrupt on these events anyway. In those modes the enables are overridden and every Start and Stop raises the interrupt.

A Stop is accepted only after the clock line has been seen low since the last Start. If SDA dips and recovers while SCL stays high, the result is a Start with no matching Stop.

Top module: `i2cc_bus_watch`

## Requirements
- R1: A Start pulse (`start_p` high for one cycle) is raised when the synchronized SDA goes from 1 to 0 while the synchronized SCL is 1 in both samples. Raw inputs reach the comparison after two clock edges, so the pulse is visible in the cycle after the second edge following the raw change.
- R2: A Stop pulse (`stop_p`) is raised when the synchronized SDA goes from 0 to 1 while SCL is 1 in both samples, provided SCL has been sampled low since the latest Start (or since reset).
- R3: If SDA falls and then rises while SCL remains high throughout, only the Start is reported and no Stop pulse appears.
- R4: A Start recognised while `bus_busy` is 1 also raises `restart_p` in the same cycle as `start_p`. A Start while idle leaves `restart_p` at 0.
- R5: `bus_busy` becomes 1 on the clock edge that ends a Start pulse. It becomes 0 on the clock edge that ends a Stop pulse.
- R6: The interrupt is set by a Start when `start_ie` or `auto_irq_mode` is 1. It is set by a Stop when `stop_ie` or `auto_irq_mode` is 1. With both the enable and the mode at 0, the event leaves `irq` unchanged.
- R7: Once set, `irq` stays 1 until `irq_clr` is 1 at a clock edge. A new event in that same cycle keeps it at 1.
- R8: After reset, `bus_busy`, `irq` and all pulses are 0, and the seen-SCL-low tracker is cleared.
- R9: If SCL and SDA both change between the same two synchronized samples, no condition is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_raw | input | 1 | Raw I2C clock line |
| sda_raw | input | 1 | Raw I2C data line |
| start_ie | input | 1 | Allow Start events to raise the interrupt |
| stop_ie | input | 1 | Allow Stop events to raise the interrupt |
| auto_irq_mode | input | 1 | Current slave mode interrupts on Start/Stop regardless of enables |
| irq_clr | input | 1 | One-cycle clear of the interrupt line |
| start_p | output | 1 | Start (including Repeated Start) pulse |
| restart_p | output | 1 | Repeated Start pulse |
| stop_p | output | 1 | Stop pulse |
| bus_busy | output | 1 | Bus is between a Start and a Stop |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench goes after the SDA blip with SCL held high. A detector without the SCL-low qualifier would report a false Stop there and drop the bus to idle mid-transfer. It drives Repeated Starts after data activity. A design that ignored bus state would never pulse `restart_p`, and one that suppressed `start_p` on a restart would leave slave logic unreset. It also changes both lines in one step, where a loose edge check would invent conditions. It mixes enable and mode settings, where a gate that ignored the mode input would miss interrupts.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
  // Synchronized line sample pair
  typedef struct packed {
    logic scl;
    logic sda;
  } i2cc_lines_t;

  localparam int LINES_W = 2;

  // SDA falling while SCL is held high across both samples
  function automatic logic fn_is_start(i2cc_lines_t prv, i2cc_lines_t cur);
    return prv.scl & cur.scl & prv.sda & ~cur.sda;
  endfunction

  // SDA rising while SCL is held high, gated by the low-seen qualifier
  function automatic logic fn_is_stop(i2cc_lines_t prv, i2cc_lines_t cur, logic low_seen);
    return prv.scl & cur.scl & ~prv.sda & cur.sda & low_seen;
  endfunction

  function automatic logic fn_irq_fire(logic st, logic sp, logic st_en, logic sp_en, logic auto_m);
    return (st & (st_en | auto_m)) | (sp & (sp_en | auto_m));
  endfunction
endpackage

// File: rtl/i2cc_sync.sv
module i2cc_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cc_cond.sv
module i2cc_cond
  import i2cc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  i2cc_lines_t cur,
  output logic        start_p,
  output logic        restart_p,
  output logic        stop_p,
  output logic        busy
);
  i2cc_lines_t prv;
  logic        low_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prv <= '{scl: 1'b1, sda: 1'b1};
    else        prv <= cur;

  assign start_p   = fn_is_start(prv, cur);
  assign stop_p    = fn_is_stop(prv, cur, low_seen);
  assign restart_p = start_p & busy;

  // Tracks whether SCL has been low since the last framing event
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               low_seen <= 1'b0;
    else if (start_p | stop_p) low_seen <= 1'b0;
    else if (!cur.scl)         low_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       busy <= 1'b0;
    else if (start_p) busy <= 1'b1;
    else if (stop_p)  busy <= 1'b0;

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n) !(start_p && stop_p));
  p_stop_qual_r3: assert property (@(posedge clk) disable iff (!rst_n) stop_p |-> low_seen);
  p_restart_busy_r4: assert property (@(posedge clk) disable iff (!rst_n) restart_p |-> (start_p && busy));
  p_busy_set_r5: assert property (@(posedge clk) disable iff (!rst_n) start_p |=> busy);
  p_busy_clr_r5: assert property (@(posedge clk) disable iff (!rst_n) stop_p |=> !busy);
  p_both_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    ((prv.scl != cur.scl) && (prv.sda != cur.sda)) |-> !(start_p || stop_p));
endmodule

// File: rtl/i2cc_irq.sv
module i2cc_irq
  import i2cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_p,
  input  logic stop_p,
  input  logic start_ie,
  input  logic stop_ie,
  input  logic auto_m,
  input  logic clr,
  output logic irq
);
  logic fire;
  assign fire = fn_irq_fire(start_p, stop_p, start_ie, stop_ie, auto_m);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    irq <= 1'b0;
    else if (fire) irq <= 1'b1;
    else if (clr)  irq <= 1'b0;

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) (irq && !clr) |=> irq);
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(start_p || stop_p));
  p_auto_r6: assert property (@(posedge clk) disable iff (!rst_n) (auto_m && (start_p || stop_p)) |=> irq);
endmodule

// File: rtl/i2cc_bus_watch.sv
module i2cc_bus_watch
  import i2cc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  input  logic start_ie,
  input  logic stop_ie,
  input  logic auto_irq_mode,
  input  logic irq_clr,
  output logic start_p,
  output logic restart_p,
  output logic stop_p,
  output logic bus_busy,
  output logic irq
);
  logic [LINES_W-1:0] raw_w, sync_w;
  i2cc_lines_t        lines_s;

  assign raw_w   = {scl_raw, sda_raw};
  assign lines_s = i2cc_lines_t'(sync_w);

  i2cc_sync #(.W(LINES_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_w), .q(sync_w)
  );

  i2cc_cond u_cond (
    .clk(clk), .rst_n(rst_n), .cur(lines_s),
    .start_p(start_p), .restart_p(restart_p), .stop_p(stop_p), .busy(bus_busy)
  );

  i2cc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
    .start_ie(start_ie), .stop_ie(stop_ie), .auto_m(auto_irq_mode),
    .clr(irq_clr), .irq(irq)
  );

  p_rst_idle_r8: assert property (@(posedge clk) $rose(rst_n) |-> (!bus_busy && !irq));
endmodule

// File: tb/i2cc_bus_watch_test.sv
`timescale 1ns/1ps
module i2cc_bus_watch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1, sda_raw = 1'b1;
  logic start_ie = 1'b0, stop_ie = 1'b0, auto_irq_mode = 1'b0, irq_clr = 1'b0;
  logic start_p, restart_p, stop_p, bus_busy, irq;

  int n_checks = 0;
  int n_errs = 0;

  // bench-side view of the bus
  logic m_scl = 1'b1, m_sda = 1'b1, m_low = 1'b0, m_busy = 1'b0, m_irq = 1'b0;

  always #2.5 clk = ~clk;

  i2cc_bus_watch uut (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .start_ie(start_ie), .stop_ie(stop_ie), .auto_irq_mode(auto_irq_mode),
    .irq_clr(irq_clr), .start_p(start_p), .restart_p(restart_p),
    .stop_p(stop_p), .bus_busy(bus_busy), .irq(irq)
  );

  task automatic check(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: got %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  // Expected Start: data line dropped, clock line high before and after
  function automatic logic want_start(logic os, logic od, logic ns, logic nd);
    return (os && ns) && (od == 1'b1) && (nd == 1'b0);
  endfunction

  function automatic logic want_stop(logic os, logic od, logic ns, logic nd, logic q);
    return q && os && ns && !od && nd;
  endfunction

  task automatic step(input logic s, input logic d, input logic sie, input logic pie, input logic am);
    logic es, ep, er, eirq;
    @(negedge clk);
    scl_raw = s; sda_raw = d; start_ie = sie; stop_ie = pie; auto_irq_mode = am;
    es = want_start(m_scl, m_sda, s, d);
    ep = want_stop(m_scl, m_sda, s, d, m_low);
    er = es && m_busy;
    eirq = (es && (sie || am)) || (ep && (pie || am));
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(start_p, es, "R1/R3/R9 start_p");
    check(stop_p, ep, "R2/R3/R9 stop_p");
    check(restart_p, er, "R4 restart_p");
    if (es) begin m_busy = 1'b1; m_low = 1'b0; end
    else if (ep) begin m_busy = 1'b0; m_low = 1'b0; end
    else if (!s) m_low = 1'b1;
    if (eirq) m_irq = 1'b1;
    m_scl = s; m_sda = d;
    @(posedge clk); @(negedge clk);
    check(bus_busy, m_busy, "R5 bus_busy");
    check(irq, m_irq, "R6/R7 irq");
    check(start_p | stop_p | restart_p, 1'b0, "R1 single-cycle pulse");
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    m_irq = 1'b0;
    check(irq, 1'b0, "R7 irq cleared");
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7531));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bus_busy, 1'b0, "R8 busy after reset");
    check(irq, 1'b0, "R8 irq after reset");
    check(start_p | stop_p | restart_p, 1'b0, "R8 pulses after reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: Stop shape right after reset with no SCL low seen -> ignored
    step(1, 0, 0, 0, 0);   // Start (idle) -> no irq (enables off)
    check(irq, 1'b0, "R6 start with enables off");
    step(1, 1, 1, 1, 0);   // R3 blip: no Stop
    check(bus_busy, 1'b1, "R3 still busy after blip");
    // data phase then proper Stop
    step(0, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    step(1, 1, 1, 1, 0);   // R2 Stop, irq via stop_ie
    check(irq, 1'b1, "R6 stop_ie raises irq");
    clear_irq();
    // Start, data, Repeated Start under auto mode with enables off
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 1);
    step(1, 1, 0, 0, 1);
    step(1, 0, 0, 0, 1);   // R4 restart
    check(irq, 1'b1, "R6 auto mode overrides enables");
    clear_irq();
    // R9: both lines change together
    step(0, 1, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    step(0, 1, 1, 1, 0);
    step(1, 1, 1, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic rs, rd;
      rs = ($urandom % 3) != 0;
      rd = $urandom % 2;
      step(rs, rd, 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      if (($urandom % 8) == 0) clear_irq();
    end
    disable watchdog;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule